// File: doc/BRIEF.md
# Chip-Select Address Window Decoder

This block sits beside a CPU bus. It decodes the upper address bits of each bus access against four programmable address windows. Each window is described by a base byte that supplies the top eight address bits, a per-bit don't-care mask, a master enable, a data bus width of 8 or 16 bits and a wait-state count of 0 to 7. An access that lands in an enabled window drives that window's active-low chip select and reports the window's bus width. The block then counts out the window's wait states and raises a one-cycle ready pulse to end the bus cycle.

An access that hits no enabled window goes to a default extra area. The extra area drives no chip select and takes its bus width and wait count from its own control byte. Software programs every setting through a small write-only register port.

A bus access is a one-cycle request pulse that carries address bits A23..A8. Bits A7..A0 never take part in the decode, so they are not brought into the block.

Top module: `csw_decoder`

## Requirements
- R1: After reset all chip selects are high, ready and the width flag are low, and every window is disabled. The extra area resets to 8-bit width with 7 wait states.
- R2: Window n matches address bits A23..A8 when every bit whose mask bit is 0 equals the same bit of {base, 8'h00}. Mask bit k covers address bit A(k+8). A window with base 01h and mask 00FFh covers 010000h..01FFFFh.
- R3: A window whose enable bit is 0 is never selected, whatever its base and mask hold.
- R4: When several enabled windows match, the lowest-numbered one is selected.
- R5: When no enabled window matches, every chip select stays high. The access then uses the extra area's width and wait count.
- R6: The selected chip select goes low in the cycle after the request. It stays low through the ready cycle and is high again in the following cycle. At most one chip select is low at any time.
- R7: Ready is high for exactly one cycle. For a wait count W that cycle is W+1 cycles after the request cycle, so W=0 gives ready in the first cycle after the request.
- R8: The width flag is 1 for a 16-bit area and 0 for an 8-bit area throughout the access, and it is 0 while idle.
- R9: A request raised while an access is in progress is ignored. The current access's chip select, width and timing are unchanged, and no second access follows.
- R10: Register addresses are {0, n[1:0], f[1:0]} for window n. Field f=0 holds the base (data bits 7:0), f=1 holds the mask (data bits 15:0) and f=2 holds the control byte (bit 7 enable, bit 4 width with 1 meaning 16-bit, bits 2:0 wait count). Address 10h holds the extra area's control byte, using the same width and wait bits. Writes to any other address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register address |
| cfg_wdata | input | 16 | Register write data |
| acc_req | input | 1 | One-cycle bus access request |
| acc_addr_hi | input | 16 | Access address bits A23..A8 |
| cs_n | output | 4 | Active-low chip selects, one per window |
| bus16 | output | 1 | 1 while the current access uses a 16-bit bus |
| rdy | output | 1 | Bus-cycle completion pulse |

## Verification
Accesses are aimed at four kinds of address. Some fall inside a single window; these separate a correct masked compare from a full compare. Some fall only inside a disabled window or an overlap of enabled windows; these separate enable gating and lowest-index priority from a plain first-hit scan. Some hit nothing; these show the fallback to the extra area's settings. The wait counts 0, 1, 2, 5 and 7 expose off-by-one errors in the ready timing. A request held high for a whole access, and writes to unmapped register addresses, show that neither one disturbs the state.

// File: rtl/csw_pkg.sv
package csw_pkg;
    localparam int NAREA     = 4;
    localparam int ADDR_W    = 24;
    localparam int BASE_W    = 8;
    localparam int CMP_W     = ADDR_W - 8;
    localparam int WAIT_W    = 3;
    localparam int AREA_BITS = $clog2(NAREA);
    localparam int IDX_W     = $clog2(NAREA + 1);
    localparam int CFG_AW    = AREA_BITS + 3;

    typedef enum logic {BW8 = 1'b0, BW16 = 1'b1} bus_w_e;

    typedef struct packed {
        logic              en;
        bus_w_e            width;
        logic [WAIT_W-1:0] wait_n;
        logic [BASE_W-1:0] base;
        logic [CMP_W-1:0]  mask;
    } area_cfg_t;

    typedef struct packed {
        logic [IDX_W-1:0]  idx;
        bus_w_e            width;
        logic [WAIT_W-1:0] wait_n;
    } pick_t;

    function automatic logic area_hit(area_cfg_t c, logic [CMP_W-1:0] a);
        logic [CMP_W-1:0] ref_bits;
        ref_bits = {c.base, {(CMP_W-BASE_W){1'b0}}};
        return c.en && (((a ^ ref_bits) & ~c.mask) == '0);
    endfunction
endpackage

// File: rtl/csw_regs.sv
module csw_regs
    import csw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [CFG_AW-1:0] addr,
    input  logic [CMP_W-1:0]  wdata,
    output area_cfg_t         cfg [NAREA],
    output bus_w_e            ext_width,
    output logic [WAIT_W-1:0] ext_wait
);
    localparam logic [1:0] F_BASE = 2'd0;
    localparam logic [1:0] F_MASK = 2'd1;
    localparam logic [1:0] F_CTRL = 2'd2;

    for (genvar g = 0; g < NAREA; g++) begin : g_area
        logic sel;
        assign sel = we && !addr[CFG_AW-1] &&
                     (addr[AREA_BITS+1:2] == AREA_BITS'(g));
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg[g] <= '0;
            end else if (sel) begin
                case (addr[1:0])
                    F_BASE: cfg[g].base <= wdata[BASE_W-1:0];
                    F_MASK: cfg[g].mask <= wdata;
                    F_CTRL: begin
                        cfg[g].en     <= wdata[7];
                        cfg[g].width  <= bus_w_e'(wdata[4]);
                        cfg[g].wait_n <= wdata[WAIT_W-1:0];
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ext_width <= BW8;
            ext_wait  <= '1;
        end else if (we && addr == {1'b1, {(CFG_AW-1){1'b0}}}) begin
            ext_width <= bus_w_e'(wdata[4]);
            ext_wait  <= wdata[WAIT_W-1:0];
        end
    end
endmodule

// File: rtl/csw_match.sv
module csw_match
    import csw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  area_cfg_t         cfg [NAREA],
    input  bus_w_e            ext_width,
    input  logic [WAIT_W-1:0] ext_wait,
    input  logic [CMP_W-1:0]  addr_hi,
    output pick_t             pick
);
    logic [NAREA-1:0] hit;

    for (genvar g = 0; g < NAREA; g++) begin : g_hit
        assign hit[g] = area_hit(cfg[g], addr_hi);
    end

    always_comb begin
        pick = '{idx: IDX_W'(NAREA), width: ext_width, wait_n: ext_wait};
        for (int i = NAREA - 1; i >= 0; i--) begin
            if (hit[i]) begin
                pick.idx    = IDX_W'(i);
                pick.width  = cfg[i].width;
                pick.wait_n = cfg[i].wait_n;
            end
        end
    end

    // R4: the chosen window hits and no lower-numbered window does
    p_lowest_wins_r4: assert property (@(posedge clk) disable iff (rst)
        (hit != '0) |-> (hit[pick.idx[AREA_BITS-1:0]] &&
                        ((hit & ((NAREA'(1) << pick.idx[AREA_BITS-1:0]) - NAREA'(1))) == '0)));
    // R5: extra area only when nothing hits
    p_extra_only_r5: assert property (@(posedge clk) disable iff (rst)
        (pick.idx == IDX_W'(NAREA)) |-> (hit == '0));
endmodule

// File: rtl/csw_wait.sv
module csw_wait
    import csw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  pick_t            pick,
    output logic [NAREA-1:0] cs_n,
    output logic             bus16,
    output logic             rdy,
    output logic             busy
);
    logic [WAIT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            cnt_q <= '0;
            cs_n  <= '1;
            bus16 <= 1'b0;
        end else if (busy) begin
            if (cnt_q == '0) begin
                busy  <= 1'b0;
                cs_n  <= '1;
                bus16 <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end else if (req) begin
            busy  <= 1'b1;
            cnt_q <= pick.wait_n;
            bus16 <= (pick.width == BW16);
            cs_n  <= (pick.idx < IDX_W'(NAREA))
                     ? ~(NAREA'(1) << pick.idx[AREA_BITS-1:0]) : '1;
        end
    end

    assign rdy = busy && (cnt_q == '0);

    // R7: zero-wait access completes in the first cycle after acceptance
    p_zero_wait_r7: assert property (@(posedge clk) disable iff (rst)
        (req && !busy && pick.wait_n == '0) |=> rdy);
    // R9: state of an access is held while it waits
    p_hold_busy_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && !rdy) |=> ($stable(cs_n) && $stable(bus16) && busy));
endmodule

// File: rtl/csw_decoder.sv
module csw_decoder
    import csw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [CMP_W-1:0]  cfg_wdata,
    input  logic              acc_req,
    input  logic [CMP_W-1:0]  acc_addr_hi,
    output logic [NAREA-1:0]  cs_n,
    output logic              bus16,
    output logic              rdy
);
    area_cfg_t         cfg [NAREA];
    bus_w_e            ext_width;
    logic [WAIT_W-1:0] ext_wait;
    pick_t             pick;
    logic              busy;

    csw_regs u_regs (
        .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .cfg(cfg), .ext_width(ext_width), .ext_wait(ext_wait)
    );

    csw_match u_match (
        .clk(clk), .rst(rst), .cfg(cfg), .ext_width(ext_width),
        .ext_wait(ext_wait), .addr_hi(acc_addr_hi), .pick(pick)
    );

    csw_wait u_wait (
        .clk(clk), .rst(rst), .req(acc_req), .pick(pick),
        .cs_n(cs_n), .bus16(bus16), .rdy(rdy), .busy(busy)
    );

    // R6: never more than one chip select low
    p_one_cs_r6: assert property (@(posedge clk) disable iff (rst)
        $countones(~cs_n) <= 1);
    // R7: ready lasts one cycle
    p_rdy_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        rdy |=> !rdy);
    // R6: chip selects released after ready
    p_cs_release_r6: assert property (@(posedge clk) disable iff (rst)
        rdy |=> (cs_n == '1));
    // R8: idle bus is quiet
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (cs_n == '1 && !bus16 && !rdy));
endmodule

// File: tb/csw_decoder_tb_top.sv
module csw_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        acc_req = 1'b0;
    logic [15:0] acc_addr_hi = '0;
    logic [3:0]  cs_n;
    logic        bus16;
    logic        rdy;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    csw_decoder dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .acc_req(acc_req), .acc_addr_hi(acc_addr_hi),
        .cs_n(cs_n), .bus16(bus16), .rdy(rdy)
    );

    // behavioural reference
    int m_base [4];
    int m_mask [4];
    int m_en   [4];
    int m_wd   [4];
    int m_w    [4];
    int x_wd, x_w;
    int m_act, m_cnt, m_area, m_b16;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 4; i++) begin
                m_base[i] = 0; m_mask[i] = 0; m_en[i] = 0; m_wd[i] = 0; m_w[i] = 0;
            end
            x_wd = 0; x_w = 7; m_act = 0; m_cnt = 0; m_area = 4; m_b16 = 0;
        end else begin
            if (m_act != 0) begin
                if (m_cnt == 0) m_act = 0;
                else m_cnt = m_cnt - 1;
            end else if (acc_req) begin
                int a;
                a = 4;
                for (int i = 3; i >= 0; i--)
                    if (m_en[i] != 0 &&
                        (((int'(acc_addr_hi) ^ (m_base[i] * 256)) & ~m_mask[i] & 16'hFFFF) == 0))
                        a = i;
                m_area = a;
                m_act = 1;
                m_cnt = (a < 4) ? m_w[a] : x_w;
                m_b16 = (a < 4) ? m_wd[a] : x_wd;
            end
            if (cfg_we) begin
                if (cfg_addr == 5'h10) begin
                    x_wd = int'(cfg_wdata[4]); x_w = int'(cfg_wdata[2:0]);
                end else if (cfg_addr[4] == 1'b0) begin
                    case (cfg_addr[1:0])
                        2'd0: m_base[cfg_addr[3:2]] = int'(cfg_wdata[7:0]);
                        2'd1: m_mask[cfg_addr[3:2]] = int'(cfg_wdata);
                        2'd2: begin
                            m_en[cfg_addr[3:2]] = int'(cfg_wdata[7]);
                            m_wd[cfg_addr[3:2]] = int'(cfg_wdata[4]);
                            m_w[cfg_addr[3:2]]  = int'(cfg_wdata[2:0]);
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            int e_cs;
            e_cs = (m_act != 0 && m_area < 4) ? (~(1 << m_area) & 15) : 15;
            chk("R6 cs_n vs model", int'(cs_n), e_cs);
            chk("R7 rdy vs model", int'(rdy), (m_act != 0 && m_cnt == 0) ? 1 : 0);
            chk("R8 bus16 vs model", int'(bus16), (m_act != 0) ? m_b16 : 0);
        end
    end

    function automatic int cs_idx(input logic [3:0] c);
        for (int i = 0; i < 4; i++) if (!c[i]) return i;
        return 4;
    endfunction

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic access(input logic [15:0] a, input int exp_area, input int exp_w,
                          input int exp_b16, input bit poke, input string tag);
        int seen, b16, waits;
        @(negedge clk);
        acc_req = 1'b1; acc_addr_hi = a;
        @(negedge clk);
        if (!poke) acc_req = 1'b0;
        else acc_addr_hi = 16'h5A00;
        seen = cs_idx(cs_n);
        b16 = int'(bus16);
        waits = 0;
        while (!rdy && waits < 20) begin
            waits++;
            @(negedge clk);
        end
        acc_req = 1'b0;
        chk({tag, " area"}, seen, exp_area);
        chk({tag, " R7 waits"}, waits, exp_w);
        chk({tag, " R8 width"}, b16, exp_b16);
        @(negedge clk);
        chk({tag, " R6 released"}, int'(cs_n), 15);
        chk({tag, " R9 no second access"}, int'(rdy), 0);
    endtask

    initial begin
        #(20 * 100000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 cs_n reset", int'(cs_n), 15);
        chk("R1 rdy reset", int'(rdy), 0);
        chk("R1 bus16 reset", int'(bus16), 0);
        // R1: all windows disabled, extra area 8-bit, 7 waits
        access(16'h0100, 4, 7, 0, 0, "R1 reset extra");

        // R10: program windows and extra area
        wr(5'h00, 16'h0001); wr(5'h01, 16'h00FF); wr(5'h02, 16'h0092);
        wr(5'h04, 16'h0040); wr(5'h05, 16'h3FFF); wr(5'h06, 16'h0080);
        wr(5'h08, 16'h0000); wr(5'h09, 16'hFFFF); wr(5'h0A, 16'h0095);
        wr(5'h0C, 16'h0080); wr(5'h0D, 16'h00FF); wr(5'h0E, 16'h0003);
        wr(5'h10, 16'h0011);

        access(16'h0123, 0, 2, 1, 0, "R2 window0 low");
        access(16'h01FF, 0, 2, 1, 0, "R2 window0 top");
        access(16'h0200, 2, 5, 1, 0, "R4 fall to window2");
        access(16'h5A00, 1, 0, 0, 0, "R2 window1 zero wait");
        access(16'h8000, 2, 5, 1, 0, "R3 disabled window3");

        wr(5'h0A, 16'h0015);
        access(16'h8000, 4, 1, 1, 0, "R5 extra after disable");
        access(16'h0200, 4, 1, 1, 0, "R5 extra miss");

        wr(5'h04, 16'h0000); wr(5'h05, 16'hFFFF);
        access(16'h0100, 0, 2, 1, 0, "R4 overlap 0 over 1");
        access(16'h3000, 1, 0, 0, 0, "R4 window1 catch-all");

        access(16'h0123, 0, 2, 1, 1, "R9 request held busy");

        wr(5'h03, 16'hFFFF); wr(5'h1F, 16'hFFFF); wr(5'h17, 16'h0000);
        access(16'h0123, 0, 2, 1, 0, "R10 unmapped writes");
        access(16'h9900, 1, 0, 0, 0, "R10 extra unchanged path");

        wr(5'h0E, 16'h0083);
        access(16'h8000, 1, 0, 0, 0, "R4 window3 enabled loses");
        wr(5'h06, 16'h0000);
        access(16'h8000, 3, 3, 0, 0, "R3 window3 after window1 off");
        wr(5'h0E, 16'h0000);
        access(16'h8000, 4, 1, 1, 0, "R5 all miss again");

        repeat (3) @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule